// File: doc/BRIEF.md
# Data Bus Mirror Orientation Detector

A memory package may be placed on either face of a board, and a package on the underside sees its 8-bit data pins in reverse order relative to one on the top. This block lets the package work out which face it sits on. After power-on reset it watches the command bytes latched on the write strobe. The host first sends a reset command (FFh) and then a status-read command (70h). The reset code reads the same in either bit order. The status code arrives unchanged on a top-mounted part and as 0Eh on a bottom-mounted part. Once one of these two pairs is seen, the block locks its orientation until the next power-on reset.

From then on every byte is passed through one of two lane mappings. The straight mapping joins pad bit i to internal bit i. The mirrored mapping joins pad bit i to internal bit W-1-i. The same mapping is applied to bytes coming in from the pads, which are registered and handed to the core with a valid pulse and a command flag. It is also applied to read data going out to the pads. The byte that reveals a bottom mounting is already delivered to the core in mirrored form, so the core sees a normal status read.

The control is a four-state machine:
- ST_HUNT: waiting for a reset command.
- ST_ARMED: a reset command has just been seen.
- ST_TOP: locked, straight mapping.
- ST_BOTTOM: locked, mirrored mapping.

Its transitions are:
- HUNT to ARMED on a reset command.
- ARMED to ARMED on a repeated reset command.
- ARMED to TOP on the status code.
- ARMED to BOTTOM on the mirrored status code.
- ARMED to HUNT on any other byte, whether command or not.
- TOP and BOTTOM hold for good.

Top module: `dq_orient_top`

## Requirements
- R1: While and right after power-on reset, orient_valid=0, orient_bottom=0 and int_dq_vld=0.
- R2: A command byte FFh followed directly by a command byte 70h sets orient_valid=1 with orient_bottom=0 one clock after the second byte is captured.
- R3: A command byte FFh followed directly by a command byte 0Eh sets orient_valid=1 and orient_bottom=1 one clock after the second byte is captured.
- R4: Captured pad bytes appear on int_dq_out unchanged while not bottom, and with pad bit i on internal bit 7-i once bottom.
- R5: ext_dq_out carries int_dq_in straight while not bottom, and reversed (internal bit i on pad bit 7-i) when bottom; ext_dq_oe equals core_drive.
- R6: The 0Eh command that decides bottom mounting is delivered on int_dq_out as 70h with int_dq_cmd=1.
- R7: Once orient_valid is 1, no later byte sequence changes orient_valid or orient_bottom until power-on reset.
- R8: If the byte after an FFh command is anything other than a 70h or 0Eh command, orientation stays undetermined with the straight mapping. The next FFh command restarts detection.
- R9: A byte is captured on each low-to-high transition of we_n. int_dq_vld pulses for exactly one cycle per capture, and int_dq_cmd holds the cle level at capture.
- R10: A 70h or 0Eh command that is not directly preceded by an FFh command leaves the orientation undetermined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| cle | input | 1 | Command latch enable from the pads |
| we_n | input | 1 | Write strobe from the pads, active low, byte taken on its rising edge |
| ext_dq_in | input | 8 | Byte arriving on the data pads |
| ext_dq_out | output | 8 | Byte driven onto the data pads |
| ext_dq_oe | output | 1 | Pad output enable |
| int_dq_in | input | 8 | Read data from the core |
| core_drive | input | 1 | Core request to drive the pads |
| int_dq_out | output | 8 | Captured byte in core bit order |
| int_dq_vld | output | 1 | One-cycle pulse when int_dq_out holds a new byte |
| int_dq_cmd | output | 1 | Captured byte was a command |
| orient_valid | output | 1 | Orientation has been decided |
| orient_bottom | output | 1 | Package is bottom-mounted (mirrored mapping) |

## Verification
Directed sequences separate the two deciding pairs (FFh-70h and FFh-0Eh) from near misses:
- a lone status code, which must not decide;
- a data byte or a foreign command after FFh, which must not decide;
- repeated FFh bytes, which keep detection armed;
- late pairs after locking, which must change nothing.

Seeded random episodes, each begun with a fresh reset, mix these codes with arbitrary bytes and command flags. A bench model predicts the state, the inbound byte and the outbound byte for each of them. Outbound checks with random core data on both orientations tell a reversed lane order apart from a straight one, because random bytes are rarely palindromes.

// File: rtl/dq_orient_pkg.sv
package dq_orient_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_TOP    = 2'd2,
        ST_BOTTOM = 2'd3
    } orient_st_t;
endpackage

// File: rtl/dq_lane_map.sv
module dq_lane_map #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         mirror,
    output logic [W-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_lane
            assign dout[i] = mirror ? din[W-1-i] : din[i];
        end
    endgenerate
endmodule

// File: rtl/dq_strobe_cap.sv
module dq_strobe_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic take
);
    logic we_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_n_q <= 1'b1;
        else        we_n_q <= we_n;
    end

    assign take = we_n & ~we_n_q;

    // R9: a capture cannot happen in two consecutive cycles
    p_take_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
endmodule

// File: rtl/dq_orient_fsm.sv
module dq_orient_fsm
    import dq_orient_pkg::*;
#(
    parameter int            W           = 8,
    parameter logic [W-1:0]  RESET_CODE  = 8'hFF,
    parameter logic [W-1:0]  STATUS_CODE = 8'h70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_take,
    input  logic         cap_cmd,
    input  logic [W-1:0] cap_byte,
    output logic         mirror_now,
    output logic         orient_valid,
    output logic         orient_bottom
);
    function automatic logic [W-1:0] flip(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = x[W-1-k];
        return r;
    endfunction

    localparam logic [W-1:0] MIR_STATUS = flip(STATUS_CODE);

    orient_st_t state_q, state_d;
    logic       cmd_take;

    assign cmd_take = cap_take & cap_cmd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (cmd_take && cap_byte == RESET_CODE) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cap_take) begin
                    if (!cap_cmd)                        state_d = ST_HUNT;
                    else if (cap_byte == RESET_CODE)     state_d = ST_ARMED;
                    else if (cap_byte == STATUS_CODE)    state_d = ST_TOP;
                    else if (cap_byte == MIR_STATUS)     state_d = ST_BOTTOM;
                    else                                 state_d = ST_HUNT;
                end
            end
            ST_TOP:    state_d = ST_TOP;
            ST_BOTTOM: state_d = ST_BOTTOM;
            default:   state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        orient_valid  = (state_q == ST_TOP) || (state_q == ST_BOTTOM);
        orient_bottom = (state_q == ST_BOTTOM);
        mirror_now    = (state_q == ST_BOTTOM) ||
                        ((state_q == ST_ARMED) && cmd_take && (cap_byte == MIR_STATUS));
    end

    // R7: a decided orientation never changes
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        orient_valid |=> (orient_valid && $stable(orient_bottom)));
    // R3: bottom is only ever reported together with a decision
    p_bottom_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        orient_bottom |-> orient_valid);
    // R2: a decision follows a captured command byte
    p_decide_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(orient_valid) |-> $past(cap_take && cap_cmd));
    // R3: bottom follows a captured mirrored status code
    p_bottom_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(orient_bottom) |-> $past(cap_byte == MIR_STATUS));
endmodule

// File: rtl/dq_orient_top.sv
module dq_orient_top #(
    parameter int           W           = 8,
    parameter logic [W-1:0] RESET_CODE  = 8'hFF,
    parameter logic [W-1:0] STATUS_CODE = 8'h70
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cle,
    input  logic         we_n,
    input  logic [W-1:0] ext_dq_in,
    output logic [W-1:0] ext_dq_out,
    output logic         ext_dq_oe,
    input  logic [W-1:0] int_dq_in,
    input  logic         core_drive,
    output logic [W-1:0] int_dq_out,
    output logic         int_dq_vld,
    output logic         int_dq_cmd,
    output logic         orient_valid,
    output logic         orient_bottom
);
    logic         take;
    logic         mirror_now;
    logic [W-1:0] in_mapped;

    dq_strobe_cap u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .we_n  (we_n),
        .take  (take)
    );

    dq_orient_fsm #(
        .W           (W),
        .RESET_CODE  (RESET_CODE),
        .STATUS_CODE (STATUS_CODE)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_take      (take),
        .cap_cmd       (cle),
        .cap_byte      (ext_dq_in),
        .mirror_now    (mirror_now),
        .orient_valid  (orient_valid),
        .orient_bottom (orient_bottom)
    );

    dq_lane_map #(.W(W)) u_map_in (
        .din    (ext_dq_in),
        .mirror (mirror_now),
        .dout   (in_mapped)
    );

    dq_lane_map #(.W(W)) u_map_out (
        .din    (int_dq_in),
        .mirror (orient_bottom),
        .dout   (ext_dq_out)
    );

    assign ext_dq_oe = core_drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_dq_out <= '0;
            int_dq_vld <= 1'b0;
            int_dq_cmd <= 1'b0;
        end else begin
            int_dq_vld <= take;
            if (take) begin
                int_dq_out <= in_mapped;
                int_dq_cmd <= cle;
            end
        end
    end

    // R9: each delivered byte is a single-cycle pulse
    p_vld_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_dq_vld |=> !int_dq_vld);
    // R4: outside a delivery the delivered byte holds
    p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_dq_vld |-> $stable(int_dq_out) || $past(!rst_n));
endmodule

// File: tb/dq_orient_top_bench.sv
module dq_orient_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cle = 1'b0;
    logic       we_n = 1'b1;
    logic [7:0] ext_dq_in = '0;
    logic [7:0] ext_dq_out;
    logic       ext_dq_oe;
    logic [7:0] int_dq_in = '0;
    logic       core_drive = 1'b0;
    logic [7:0] int_dq_out;
    logic       int_dq_vld, int_dq_cmd, orient_valid, orient_bottom;

    int vectors = 0;
    int fails = 0;
    int m_st = 0;   // 0 hunt, 1 armed, 2 top, 3 bottom
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dq_orient_top u_dq_orient_top (
        .clk(clk), .rst_n(rst_n), .cle(cle), .we_n(we_n),
        .ext_dq_in(ext_dq_in), .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe),
        .int_dq_in(int_dq_in), .core_drive(core_drive),
        .int_dq_out(int_dq_out), .int_dq_vld(int_dq_vld), .int_dq_cmd(int_dq_cmd),
        .orient_valid(orient_valid), .orient_bottom(orient_bottom)
    );

    function automatic logic [7:0] rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = x[7-k];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we_n = 1'b1; cle = 1'b0; core_drive = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", orient_valid, 0);
        check("R1 bottom", orient_bottom, 0);
        check("R1 vld", int_dq_vld, 0);
        rst_n = 1'b1;
        m_st = 0;
        @(negedge clk);
        check("R1 valid after release", orient_valid, 0);
    endtask

    task automatic send(input logic c, input logic [7:0] b, input string req);
        logic [7:0] exp_b;
        bit mir;
        mir = (m_st == 3) || (m_st == 1 && c && b == 8'h0E);
        exp_b = mir ? rev8(b) : b;
        case (m_st)
            0: if (c && b == 8'hFF) m_st = 1;
            1: begin
                if (!c) m_st = 0;
                else if (b == 8'hFF) m_st = 1;
                else if (b == 8'h70) m_st = 2;
                else if (b == 8'h0E) m_st = 3;
                else m_st = 0;
            end
            default: ;
        endcase
        @(negedge clk);
        we_n = 1'b0; cle = c; ext_dq_in = b;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        check({req, " R9 vld"}, int_dq_vld, 1);
        check({req, " R9 cmd"}, int_dq_cmd, c);
        check({req, " R4 byte"}, int_dq_out, exp_b);
        check({req, " valid"}, orient_valid, (m_st >= 2));
        check({req, " bottom"}, orient_bottom, (m_st == 3));
        @(negedge clk);
        check({req, " R9 pulse end"}, int_dq_vld, 0);
    endtask

    task automatic check_out(input string req);
        logic [7:0] d;
        logic oe;
        d = 8'($urandom);
        oe = 1'($urandom);
        int_dq_in = d; core_drive = oe;
        #1;
        check({req, " R5 out"}, ext_dq_out, (m_st == 3) ? rev8(d) : d);
        check({req, " R5 oe"}, ext_dq_oe, oe);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C1E));
        // R1 and R2: top pair
        do_reset();
        check_out("R5 pre");
        send(1, 8'hFF, "R2 reset");
        send(1, 8'h70, "R2 status");
        check("R2 top valid", orient_valid, 1);
        check("R2 top side", orient_bottom, 0);
        check_out("R5 top");
        // R7: later mirrored pair ignored
        send(1, 8'hFF, "R7 late reset");
        send(1, 8'h0E, "R7 late mirrored");
        check("R7 still top", orient_bottom, 0);

        // R3 and R6: bottom pair
        do_reset();
        send(1, 8'hFF, "R3 reset");
        send(1, 8'h0E, "R6 mirrored status");
        check("R3 bottom", orient_bottom, 1);
        check_out("R5 bottom");
        send(0, 8'h01, "R4 data bottom");
        send(1, 8'hFF, "R7 late reset");
        send(1, 8'h70, "R7 late status");
        check("R7 still bottom", orient_bottom, 1);

        // R10: lone status codes
        do_reset();
        send(1, 8'h70, "R10 lone status");
        send(1, 8'h0E, "R10 lone mirrored");
        check("R10 undetermined", orient_valid, 0);

        // R8: non-command and foreign command after FF, then restart
        do_reset();
        send(1, 8'hFF, "R8 reset");
        send(0, 8'h70, "R8 data after reset");
        send(1, 8'h0E, "R8 mirrored not armed");
        check("R8 undetermined", orient_valid, 0);
        send(1, 8'hFF, "R8 reset again");
        send(1, 8'h90, "R8 foreign cmd");
        check("R8 still undetermined", orient_valid, 0);
        check_out("R8 straight");
        send(1, 8'hFF, "R8 restart");
        send(1, 8'hFF, "R8 repeat reset");
        send(1, 8'h0E, "R8 restart bottom");
        check("R8 restart decided", orient_bottom, 1);

        // random episodes
        for (int ep = 0; ep < 12; ep++) begin
            do_reset();
            for (int n = 0; n < 20; n++) begin
                logic [7:0] b;
                logic c;
                case ($urandom % 5)
                    0: b = 8'hFF;
                    1: b = 8'h70;
                    2: b = 8'h0E;
                    default: b = 8'($urandom);
                endcase
                c = (($urandom % 4) != 0);
                send(c, b, "R4 random");
                if ((n % 5) == 4) check_out("R5 random");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule